// File: doc/BRIEF.md
# Vector Unit Precise Trap Flush Controller

This block sequences a precise trap inside a vector coprocessor when the scalar core reports a fault that surfaced late, for example a bus error seen as a load/store transaction completes. The scalar core raises a trap request together with the reorder-buffer index of the faulting instruction. The controller stores that index and stalls the instruction intake of the command queue. It then pulses a flush to the command queue and to the micro-op queue, and waits while the micro-ops already in the execute, memory and writeback stages run to completion.

Retirements reach the controller as a valid bit and a reorder-buffer index. Retirement is in order, so the drain ends when the entry that sits just before the faulting one retires. The predecessor is found with modulo-32 arithmetic, so it is correct across index wrap. If the scalar core reports that the oldest outstanding entry already is the faulting one, no drain is needed. The controller then presents a trap-ready response as a valid/ready handshake. It releases the stall when the scalar core accepts that response.

Top module: `vtrap_flush_ctrl`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and after it is released with no request, the stall, both flush outputs and the ready-valid output are 0.
- R2: A trap request sampled while the controller is idle drives both queue flush outputs to 1 in the following cycle.
- R3: Each accepted trap request produces exactly one cycle of both flush outputs.
- R4: The captured faulting index F defines the drain end. A retirement with index (F-1) mod 32, seen in the flush cycle or in any later drain cycle, raises the ready-valid output in the next cycle.
- R5: If the oldest-outstanding index input equals the request index at capture, ready-valid rises in the cycle right after the flush cycle.
- R6: During the drain, a retirement of any index other than (F-1) mod 32 leaves ready-valid at 0. This covers indexes older than the predecessor, the faulting index itself, and younger indexes.
- R7: Once raised, ready-valid stays 1 until a cycle in which the acknowledge input is 1. In the next cycle, ready-valid and the stall are 0 and the controller is idle.
- R8: A trap request that arrives before the controller is idle again does not replace the captured index and causes no further flush.
- R9: The intake stall is 1 from the cycle after an accepted request up to and including the acknowledge cycle.
- R10: The predecessor test wraps. With F = 0, the retirement of index 31 ends the drain.
- R11: An acknowledge input given while ready-valid is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Trap request from the scalar core |
| trap_rob_i | input | 5 | Reorder-buffer index of the faulting instruction |
| head_rob_i | input | 5 | Index of the oldest reorder-buffer entry not yet retired |
| ret_valid_i | input | 1 | A micro-op retired this cycle |
| ret_rob_i | input | 5 | Reorder-buffer index of the retiring micro-op |
| cq_stall_o | output | 1 | Blocks the command queue from accepting instructions |
| cq_flush_o | output | 1 | One-cycle command queue flush |
| uq_flush_o | output | 1 | One-cycle micro-op queue flush |
| trap_rdy_valid_o | output | 1 | Trap-ready response to the scalar core |
| trap_rdy_ack_i | input | 1 | Scalar core accepts the trap-ready response |

## Verification
The flush outputs and the stall are due one cycle after the clock edge that samples the request. The ready-valid response is due one cycle after the edge that samples the predecessor's retirement, or two cycles after the request when no drain is needed. The release of the stall is due one cycle after the acknowledge edge. The bench applies stimulus on the falling edge and advances a behavioural model on each rising edge. It compares every output with the model on the following falling edge, so each result is checked exactly in the cycle it is due. Stray retirements, repeated requests and early acknowledges are included so that any early or late transition shows up as a mismatch in that cycle.

// File: rtl/vtrap_flush_ctrl.sv
module vtrap_flush_ctrl #(
  parameter int ROB_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req_i,
  input  logic [ROB_W-1:0] trap_rob_i,
  input  logic [ROB_W-1:0] head_rob_i,
  input  logic             ret_valid_i,
  input  logic [ROB_W-1:0] ret_rob_i,
  output logic             cq_stall_o,
  output logic             cq_flush_o,
  output logic             uq_flush_o,
  output logic             trap_rdy_valid_o,
  input  logic             trap_rdy_ack_i
);

  localparam logic [ROB_W-1:0] ONE = ROB_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_DRAIN, S_ACK} state_t;

  state_t           state_q, state_d;
  logic [ROB_W-1:0] fault_q;
  logic             empty_q;
  logic [ROB_W-1:0] age_gap;
  logic             pred_hit;
  logic             accept;

  assign accept   = (state_q == S_IDLE) && trap_req_i;
  assign age_gap  = fault_q - ret_rob_i;
  assign pred_hit = ret_valid_i && (age_gap == ONE) &&
                    ((state_q == S_FLUSH) || (state_q == S_DRAIN));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (trap_req_i) state_d = S_FLUSH;
      S_FLUSH: state_d = (empty_q || pred_hit) ? S_ACK : S_DRAIN;
      S_DRAIN: if (pred_hit) state_d = S_ACK;
      S_ACK:   if (trap_rdy_ack_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fault_q <= '0;
      empty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        fault_q <= trap_rob_i;
        empty_q <= (head_rob_i == trap_rob_i);
      end
    end
  end

  assign cq_stall_o       = (state_q != S_IDLE);
  assign cq_flush_o       = (state_q == S_FLUSH);
  assign uq_flush_o       = (state_q == S_FLUSH);
  assign trap_rdy_valid_o = (state_q == S_ACK);

  // R2
  a_r2_flush_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!cq_stall_o && trap_req_i) |=> (cq_flush_o && uq_flush_o));
  // R3
  a_r3_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cq_flush_o |=> !cq_flush_o);
  // R7
  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_rdy_valid_o && !trap_rdy_ack_i) |=> trap_rdy_valid_o);
  // R7
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_rdy_valid_o && trap_rdy_ack_i) |=> (!cq_stall_o && !trap_rdy_valid_o));
  // R9
  a_r9_stall_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_flush_o || trap_rdy_valid_o) |-> cq_stall_o);
  // R8
  a_r8_fault_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_stall_o && !(trap_rdy_valid_o && trap_rdy_ack_i)) |=> $stable(fault_q));
  // R4
  a_r4_ready_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_stall_o && !trap_rdy_valid_o && !empty_q &&
     !(ret_valid_i && (fault_q - ret_rob_i) == ONE)) |=> !trap_rdy_valid_o);

endmodule

// File: tb/tb_vtrap_flush_ctrl.sv
module tb_vtrap_flush_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trap_req_i = 1'b0;
  logic [4:0] trap_rob_i = '0;
  logic [4:0] head_rob_i = '0;
  logic       ret_valid_i = 1'b0;
  logic [4:0] ret_rob_i = '0;
  logic       trap_rdy_ack_i = 1'b0;
  logic       cq_stall_o, cq_flush_o, uq_flush_o, trap_rdy_valid_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // model: 0 idle, 1 flush, 2 drain, 3 ack
  int m_st = 0;
  int m_fault = 0;
  bit m_empty = 0;

  always #5 clk = ~clk;

  vtrap_flush_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .trap_req_i(trap_req_i), .trap_rob_i(trap_rob_i), .head_rob_i(head_rob_i),
    .ret_valid_i(ret_valid_i), .ret_rob_i(ret_rob_i),
    .cq_stall_o(cq_stall_o), .cq_flush_o(cq_flush_o), .uq_flush_o(uq_flush_o),
    .trap_rdy_valid_o(trap_rdy_valid_o), .trap_rdy_ack_i(trap_rdy_ack_i)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_fault = 0; m_empty = 0;
    end else begin
      bit hit;
      hit = ret_valid_i && (((m_fault + 32 - int'(ret_rob_i)) % 32) == 1);
      case (m_st)
        0: if (trap_req_i) begin
             m_st = 1; m_fault = int'(trap_rob_i); m_empty = (head_rob_i == trap_rob_i);
           end
        1: m_st = (m_empty || hit) ? 3 : 2;
        2: if (hit) m_st = 3;
        default: if (trap_rdy_ack_i) m_st = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cycles, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    cycles++;
    chk({tag, " stall (R9)"}, cq_stall_o, m_st != 0);
    chk({tag, " cq flush (R2/R3)"}, cq_flush_o, m_st == 1);
    chk({tag, " uq flush (R2/R3)"}, uq_flush_o, m_st == 1);
    chk({tag, " ready (R4/R7)"}, trap_rdy_valid_o, m_st == 3);
  endtask

  task automatic clr();
    trap_req_i = 0; ret_valid_i = 0; trap_rdy_ack_i = 0;
  endtask

  task automatic req(input int f, input int h);
    trap_req_i = 1; trap_rob_i = 5'(f); head_rob_i = 5'(h);
  endtask

  task automatic ret(input int r);
    ret_valid_i = 1; ret_rob_i = 5'(r);
  endtask

  initial begin
    #1;
    chk("R1 stall in reset", cq_stall_o, 1'b0);
    chk("R1 flush in reset", cq_flush_o, 1'b0);
    chk("R1 ready in reset", trap_rdy_valid_o, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    cyc("R1 idle");
    trap_rdy_ack_i = 1; cyc("R11 stray ack"); clr();

    // drain from 5 to 10 with stray retirements and a second request
    req(10, 5); cyc("R2 accept");
    clr(); ret(20); cyc("R6 younger");
    clr(); req(3, 3); ret(5); cyc("R8 second req");
    clr(); ret(10); cyc("R6 same index");
    clr(); ret(2); cyc("R8 would end if captured");
    for (int i = 6; i <= 8; i++) begin clr(); ret(i); cyc("R6 older"); end
    clr(); trap_rdy_ack_i = 1; cyc("R11 early ack");
    clr(); ret(9); cyc("R4 predecessor");
    clr(); cyc("R7 hold");
    cyc("R7 hold");
    trap_rdy_ack_i = 1; cyc("R7 ack");
    clr(); cyc("R7 idle after ack");

    // nothing older outstanding
    req(7, 7); cyc("R5 accept");
    clr(); cyc("R5 flush");
    cyc("R5 ready");
    trap_rdy_ack_i = 1; req(1, 0); cyc("R8 ack with req");
    clr(); cyc("R7 released");

    // wrap-around drain
    req(0, 28); cyc("R10 accept");
    clr(); ret(28); cyc("R10 flush");
    for (int i = 29; i <= 30; i++) begin clr(); ret(i); cyc("R10 older"); end
    clr(); ret(31); cyc("R10 predecessor");
    clr(); cyc("R10 ready");
    trap_rdy_ack_i = 1; cyc("R7 ack");
    clr(); cyc("R7 idle");

    // predecessor retires during the flush cycle
    req(4, 3); cyc("R4 accept");
    clr(); ret(3); cyc("R4 flush-cycle hit");
    clr(); cyc("R4 ready");
    trap_rdy_ack_i = 1; cyc("R7 ack");
    clr(); cyc("R7 idle");

    // back-to-back traps
    req(15, 14); cyc("R2 accept again");
    clr(); cyc("R3 one pulse");
    ret(14); cyc("R4 hit");
    clr(); trap_rdy_ack_i = 1; cyc("R7 ack");
    clr(); req(16, 16); cyc("R2 next trap");
    clr(); cyc("R5");
    cyc("R5 ready");
    trap_rdy_ack_i = 1; cyc("R7 ack");
    clr(); cyc("R7 idle");
    repeat (3) cyc("R1 quiet");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule